// File: doc/BRIEF.md
# Two's Complement Subtractor with Status Flags

This block takes two 8-bit operands and either subtracts or adds them. It reports the 8-bit outcome together with four status flags: carry, overflow, zero and negative. To subtract, the block forms the two's complement negation of the second operand (every bit inverted, then one added) and feeds that value to a ripple adder together with the first operand. The carry flag is the ninth bit of that whole sum. After a subtraction a set carry therefore means that no borrow occurred.

The overflow flag follows the operand-sign rule and is applied to the two values that actually reach the adder. It is set when both adder operands carry the same sign bit and the sum's sign bit differs from it. When the second operand is the most negative value (80h), its negation is 80h again, and the flag follows the rule on that 80h operand. An elaboration parameter places a register stage with a synchronous active-low reset on the outputs, or leaves the outputs purely combinational.

Top module: `sub_flag_unit`

## Requirements
- R1: With `op_sub`=1, `result` equals (a − b) modulo 256.
- R2: With `op_sub`=1, `c_flag` is the ninth bit of a + (bitwise-inverted b) + 1. It is 1 exactly when a ≥ b taken as unsigned numbers, meaning no borrow.
- R3: With `op_sub`=1, `v_flag` is 1 exactly when a[7] equals bit 7 of the negated operand (256 − b) mod 256 and result[7] differs from a[7].
- R4: With `op_sub`=1 and b = 80h, the negated operand is 80h. `v_flag` is then 1 exactly when a[7]=1 and result[7]=0. For example 00h − 80h gives 80h with V=0, and 80h − 80h gives 00h with C=1 and V=1.
- R5: With `op_sub`=0, b reaches the adder unchanged with no carry-in. `result` is (a + b) mod 256, `c_flag` is bit 8 of a + b, and `v_flag` is 1 exactly when a[7]=b[7] and result[7]≠a[7].
- R6: `z_flag` is 1 exactly when `result` is 00h.
- R7: `n_flag` equals bit 7 of `result`.
- R8: 92h − 64h gives `result` 2Eh with `c_flag`=1 and `v_flag`=1.
- R9: With `REG_OUT`=1, the outputs show the operation presented one clock earlier. While `rst_n` is low at a rising edge, `result` and all flags become 0 at that edge.
- R10: `op_sub`=1 selects subtraction and `op_sub`=0 selects addition, chosen on the same cycle as the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| a | input | 8 | First operand (minuend or addend) |
| b | input | 8 | Second operand (subtrahend or addend) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| result | output | 8 | Low 8 bits of the adder sum |
| c_flag | output | 1 | Ninth bit of the adder sum |
| v_flag | output | 1 | Operand-sign overflow |
| z_flag | output | 1 | Result is zero |
| n_flag | output | 1 | Sign bit of the result |

## Verification
The assertions sample the operands and the mode select at each rising edge. They assume these inputs are settled and known there, and they treat each cycle as one independent operation with no carry from the previous cycle. The bench changes `a`, `b` and `op_sub` only on falling edges, so every value seen at a rising edge is stable. The bench then sweeps every operand pair in both modes, so the 80h subtrahend and the zero operands all appear. The check on the output register assumes that one full cycle with reset deasserted has passed, and the bench begins its sweep only after reset has been released.

// File: rtl/sub_flag_pkg.sv
// Package: shared types for the subtractor with status flags.
// Assumes: the flag bundle is the same for every operand width.
package sub_flag_pkg;

    // Status flags produced with every result.
    typedef struct packed {
        logic c;  // ninth bit of the adder sum
        logic v;  // operand-sign overflow
        logic z;  // result is zero
        logic n;  // result sign bit
    } flag_t;

endpackage

// File: rtl/operand_prep.sv
// operand_prep: chooses the second adder operand. In subtract mode it
// forms the two's complement negation of b (bits inverted, then a rippled
// increment). In add mode it passes b through unchanged.
// Assumes: op_sub is settled in the same cycle as b. neg_carry is the
// carry out of the increment, which is 1 only when b is zero in subtract mode.
module operand_prep #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] b,
    input  logic         op_sub,
    output logic [W-1:0] opnd,
    output logic         neg_carry
);
    logic [W-1:0] inv;
    logic [W:0]   inc_c;
    logic [W-1:0] neg;

    // Invert every bit of the subtrahend.
    always_comb inv = ~b;

    assign inc_c[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_inc
        // One stage of the +1 ripple incrementer.
        always_comb begin
            neg[i]       = inv[i] ^ inc_c[i];
            inc_c[i + 1] = inv[i] & inc_c[i];
        end
    end

    // Pick the negated or the plain operand.
    always_comb begin
        opnd      = op_sub ? neg : b;
        neg_carry = op_sub & inc_c[W];
    end

    // R3: the operand fed in subtract mode cancels b modulo 2^W.
    assert_negate_cancels_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_sub |-> ((opnd + b) == '0));

    // R2: the increment carries out only for a zero subtrahend.
    assert_negcarry_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        neg_carry |-> (b == '0));
endmodule

// File: rtl/ripple_adder.sv
// ripple_adder: plain carry-ripple adder built from W full-adder cells.
// Assumes: no carry-in. Subtract mode supplies its +1 through operand_prep.
module ripple_adder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] cy;

    assign cy[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_fa
        // One full-adder cell of the chain.
        always_comb begin
            sum[i]    = x[i] ^ y[i] ^ cy[i];
            cy[i + 1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
        end
    end

    // Expose the final carry.
    always_comb cout = cy[W];

    // R1: the chain agrees with a W+1 bit arithmetic sum.
    assert_chain_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        {cout, sum} == ({1'b0, x} + {1'b0, y}));
endmodule

// File: rtl/flag_gen.sv
// flag_gen: derives carry, overflow, zero and negative from the adder sum.
// Assumes: opnd_sign is the sign of the operand actually fed to the adder.
// neg_carry is the carry lost when that operand was formed.
module flag_gen #(
    parameter int W = 8
) (
    input  logic                  a_sign,
    input  logic                  opnd_sign,
    input  logic [W-1:0]          sum,
    input  logic                  add_cout,
    input  logic                  neg_carry,
    output sub_flag_pkg::flag_t   flags
);
    // Combine the adder status into the flag bundle.
    always_comb begin
        flags.c = add_cout | neg_carry;
        flags.v = (a_sign == opnd_sign) && (sum[W-1] != a_sign);
        flags.z = (sum == '0);
        flags.n = sum[W-1];
    end
endmodule

// File: rtl/out_stage.sv
// out_stage: optional output register with synchronous active-low reset.
// With REG_OUT=0 the values pass straight through.
// Assumes: in the registered variant, clk is free-running.
module out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        res_i,
    input  sub_flag_pkg::flag_t flg_i,
    output logic [W-1:0]        res_o,
    output sub_flag_pkg::flag_t flg_o
);
    if (REG_OUT) begin : g_reg
        // Capture the result and flags, cleared while reset is low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_o <= '0;
                flg_o <= '0;
            end else begin
                res_o <= res_i;
                flg_o <= flg_i;
            end
        end

        // R9: one clock of latency once reset has been released.
        assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (res_o == $past(res_i) && flg_o == $past(flg_i)));
    end else begin : g_comb
        // Pass the values through unregistered.
        always_comb begin
            res_o = res_i;
            flg_o = flg_i;
        end
    end
endmodule

// File: rtl/sub_flag_unit.sv
// sub_flag_unit: add/subtract unit with carry, overflow, zero, negative.
// Subtract computes a + (~b + 1). C is the ninth bit of that total and
// V uses the sign rule on the operands as fed to the adder.
// Assumes: a, b and op_sub are stable at each rising clock edge.
module sub_flag_unit #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         op_sub,
    output logic [W-1:0] result,
    output logic         c_flag,
    output logic         v_flag,
    output logic         z_flag,
    output logic         n_flag
);
    import sub_flag_pkg::*;

    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] opnd;
    logic         neg_carry;
    logic [W-1:0] sum_w;
    logic         add_cout;
    flag_t        flags;
    flag_t        flags_q;

    operand_prep #(.W(W)) u_prep (
        .clk(clk), .rst_n(rst_n), .b(b), .op_sub(op_sub),
        .opnd(opnd), .neg_carry(neg_carry)
    );

    ripple_adder #(.W(W)) u_add (
        .clk(clk), .rst_n(rst_n), .x(a), .y(opnd),
        .sum(sum_w), .cout(add_cout)
    );

    flag_gen #(.W(W)) u_flags (
        .a_sign(a[W-1]), .opnd_sign(opnd[W-1]), .sum(sum_w),
        .add_cout(add_cout), .neg_carry(neg_carry), .flags(flags)
    );

    out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .res_i(sum_w), .flg_i(flags),
        .res_o(result), .flg_o(flags_q)
    );

    // Unpack the flag bundle onto the ports.
    always_comb begin
        c_flag = flags_q.c;
        v_flag = flags_q.v;
        z_flag = flags_q.z;
        n_flag = flags_q.n;
    end

    // R1 / R10: subtract mode yields the modular difference.
    assert_sub_diff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_sub |-> (sum_w == (a - b)));

    // R2: carry means no unsigned borrow.
    assert_no_borrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_sub |-> (flags.c == (a >= b)));

    // R3: apart from b = MINV, V matches true signed overflow.
    assert_sub_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sub && b != MINV) |->
            (flags.v == ((a[W-1] != b[W-1]) && (sum_w[W-1] != a[W-1]))));

    // R4: a MINV subtrahend obeys the rule on the MINV operand.
    assert_min_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sub && b == MINV) |-> (flags.v == (a[W-1] && !sum_w[W-1])));

    // R5 / R10: add mode yields the plain sum and carry.
    assert_add_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !op_sub |-> ({flags.c, sum_w} == ({1'b0, a} + {1'b0, b})));

    // R6 / R7: zero and negative can never be set together.
    assert_zn_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags.z, flags.n}));
endmodule

// File: tb/sub_flag_unit_test.sv
module sub_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic       op_sub = 1'b0;
    logic [7:0] result;
    logic       c_flag, v_flag, z_flag, n_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    sub_flag_unit #(.W(8), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op_sub(op_sub),
        .result(result), .c_flag(c_flag), .v_flag(v_flag),
        .z_flag(z_flag), .n_flag(n_flag)
    );

    // Expected result and flags, worked out from the requirements.
    task automatic expect_of(input logic [7:0] ea, input logic [7:0] eb, input logic es,
                             output logic [7:0] r, output logic c, output logic v,
                             output logic z, output logic n);
        int s;
        logic [7:0] o;
        if (es) begin
            s = int'(ea) - int'(eb);
            r = 8'(s + 256);
            c = (ea >= eb);
            o = 8'(256 - int'(eb));
        end else begin
            s = int'(ea) + int'(eb);
            r = 8'(s);
            c = (s > 255);
            o = eb;
        end
        v = (ea[7] == o[7]) && (r[7] != ea[7]);
        z = (r == 8'h00);
        n = r[7];
    endtask

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Compare every output with the model for the given operation.
    task automatic check_all(input logic [7:0] ea, input logic [7:0] eb, input logic es);
        logic [7:0] r;
        logic c, v, z, n;
        expect_of(ea, eb, es, r, c, v, z, n);
        cmp(es ? "R1 result" : "R5/R10 result", result, r);
        cmp(es ? "R2 carry" : "R5 carry", {7'b0, c_flag}, {7'b0, c});
        cmp(es ? ((eb == 8'h80) ? "R4 overflow" : "R3 overflow") : "R5 overflow",
            {7'b0, v_flag}, {7'b0, v});
        cmp("R6 zero", {7'b0, z_flag}, {7'b0, z});
        cmp("R7 negative", {7'b0, n_flag}, {7'b0, n});
    endtask

    // One directed operation: drive, wait one register stage, compare.
    task automatic directed(input logic [7:0] da, input logic [7:0] db, input logic ds);
        @(negedge clk);
        a = da; b = db; op_sub = ds;
        @(negedge clk);
        check_all(da, db, ds);
    endtask

    initial begin
        // R9: reset clears the outputs even with nonzero operands.
        a = 8'hFF; b = 8'h01; op_sub = 1'b0;
        repeat (3) @(negedge clk);
        cmp("R9 reset result", result, 8'h00);
        cmp("R9 reset flags", {4'b0, c_flag, v_flag, z_flag, n_flag}, 8'h00);
        rst_n = 1'b1;

        // R8: worked example 92h - 64h.
        @(negedge clk);
        a = 8'h92; b = 8'h64; op_sub = 1'b1;
        @(negedge clk);
        cmp("R8 result", result, 8'h2E);
        cmp("R8 carry", {7'b0, c_flag}, 8'h01);
        cmp("R8 overflow", {7'b0, v_flag}, 8'h01);

        // R4: 80h subtrahend corner cases.
        directed(8'h00, 8'h80, 1'b1);
        cmp("R4 00-80 overflow", {7'b0, v_flag}, 8'h00);
        directed(8'h80, 8'h80, 1'b1);
        cmp("R4 80-80 overflow", {7'b0, v_flag}, 8'h01);
        cmp("R4 80-80 carry", {7'b0, c_flag}, 8'h01);
        // R2: zero subtrahend still carries.
        directed(8'h37, 8'h00, 1'b1);
        cmp("R2 zero subtrahend carry", {7'b0, c_flag}, 8'h01);
        // R5: signed add overflow 7Fh + 01h.
        directed(8'h7F, 8'h01, 1'b0);
        cmp("R5 7F+01 overflow", {7'b0, v_flag}, 8'h01);
        // R6: FFh + 01h gives zero with carry.
        directed(8'hFF, 8'h01, 1'b0);
        cmp("R6 zero from add", {7'b0, z_flag}, 8'h01);

        // R9 / R10: pipelined exhaustive sweep over both modes. Each
        // vector is checked one cycle after it was applied.
        begin
            logic [7:0] pa, pb;
            logic ps;
            bit valid;
            valid = 1'b0;
            pa = '0; pb = '0; ps = 1'b0;
            for (int m = 0; m < 2; m++) begin
                for (int i = 0; i < 256; i++) begin
                    for (int j = 0; j < 256; j++) begin
                        @(negedge clk);
                        if (valid) check_all(pa, pb, ps);
                        a = 8'(i); b = 8'(j); op_sub = (m == 1);
                        pa = 8'(i); pb = 8'(j); ps = (m == 1);
                        valid = 1'b1;
                    end
                end
            end
            @(negedge clk);
            check_all(pa, pb, ps);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule